// File: doc/BRIEF.md
# Subtractive GCD Unit

The unit computes the greatest common divisor of two unsigned operands by repeated subtraction. A start pulse captures both operands. After that, the larger of the two working values is reduced by the smaller, one subtraction per clock cycle, until the two values match. The result is then placed in a registered output and the unit goes back to waiting for the next start.

The design is split into a datapath and a controller. The datapath has two operand lanes. Each lane has a register, a two-way input select and its own subtractor. The datapath also holds the result register and produces two status flags. The controller is a two-state machine. It sees only those two flags and drives the lane selects, the lane load enables and the result load.

A zero operand is handled inside the datapath. If either working value is zero, the inequality flag is reported as clear and the result register takes the other value. The unit therefore finishes at once instead of looping.

Top module: `gcd_sub_unit`

## Requirements
- R1: After reset is released, `gcd_o` is 0 and `done_o` is 0.
- R2: While idle, a cycle with `start_i` at 1 captures `opa_i` and `opb_i` as the working values. While idle with `start_i` at 0, nothing changes.
- R3: For nonzero operands a and b, `gcd_o` holds gcd(a, b) when `done_o` is 1. In each step the larger working value is replaced by its difference with the smaller one.
- R4: If one operand is zero, the result is the other operand. If both are zero, the result is 0. No subtraction step is taken in either case.
- R5: Latency is fixed by the number of steps. `done_o` rises on the (s+2)-th rising edge counted from the edge that captured the operands (that edge counts as the first), where s is the number of subtraction steps the operand pair needs. Equal operands and zero operands give s = 0.
- R6: `done_o` is high for exactly one cycle, on the same edge that updates `gcd_o`. `gcd_o` holds its value at all other times.
- R7: `start_i` and the operand inputs are ignored while a computation is in progress. A start seen while busy is not queued.
- R8: After `done_o`, the unit is idle again. A `start_i` held at 1 through the result cycle is accepted on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, sampled only while idle |
| opa_i | input | W | First operand |
| opb_i | input | W | Second operand |
| gcd_o | output | W | Registered result |
| done_o | output | 1 | One-cycle pulse marking a new result |

## Verification
The result load and a new start request can land in the same cycle. In that cycle the controller is still deciding, so the request is ignored there and is taken one edge later. The bench provokes this by holding `start_i` high across consecutive computations. It checks that the second result appears exactly s+2 edges after the first `done_o`. The bench also pulses `start_i` with different operands during a computation and checks that the result is unchanged and that no extra `done_o` follows.

// File: rtl/gcd_pkg.sv
package gcd_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_STEP = 1'b1
  } gcd_state_e;
endpackage

// File: rtl/gcd_operand_lane.sv
module gcd_operand_lane #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] ext_i,
  input  logic [W-1:0] other_i,
  input  logic         sel_i,
  input  logic         ld_i,
  output logic [W-1:0] val_o
);
  logic [W-1:0] diff;
  logic [W-1:0] nxt;

  assign diff = val_o - other_i;
  assign nxt  = sel_i ? diff : ext_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   val_o <= '0;
    else if (ld_i) val_o <= nxt;
  end
endmodule

// File: rtl/gcd_datapath.sv
module gcd_datapath #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] opa_i,
  input  logic [W-1:0] opb_i,
  input  logic         sel_a_i,
  input  logic         sel_b_i,
  input  logic         ld_a_i,
  input  logic         ld_b_i,
  input  logic         ld_res_i,
  output logic         a_ne_b_o,
  output logic         a_lt_b_o,
  output logic [W-1:0] a_o,
  output logic [W-1:0] b_o,
  output logic [W-1:0] res_o
);
  localparam int NL = 2;

  logic [NL-1:0][W-1:0] ext;
  logic [NL-1:0][W-1:0] val;
  logic [NL-1:0]        sel;
  logic [NL-1:0]        ld;

  assign ext = {opb_i, opa_i};
  assign sel = {sel_b_i, sel_a_i};
  assign ld  = {ld_b_i, ld_a_i};

  for (genvar g = 0; g < NL; g++) begin : g_lane
    gcd_operand_lane #(.W(W)) u_lane (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .ext_i   (ext[g]),
      .other_i (val[NL-1-g]),
      .sel_i   (sel[g]),
      .ld_i    (ld[g]),
      .val_o   (val[g])
    );
  end

  assign a_o = val[0];
  assign b_o = val[1];

  // a zero working value stops iteration
  logic any_zero;
  assign any_zero = (a_o == '0) || (b_o == '0);
  assign a_ne_b_o = (a_o != b_o) && !any_zero;
  assign a_lt_b_o = a_o < b_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       res_o <= '0;
    else if (ld_res_i) res_o <= (a_o == '0) ? b_o : a_o;
  end
endmodule

// File: rtl/gcd_ctrl.sv
module gcd_ctrl
  import gcd_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic a_ne_b_i,
  input  logic a_lt_b_i,
  output logic sel_a_o,
  output logic sel_b_o,
  output logic ld_a_o,
  output logic ld_b_o,
  output logic ld_res_o,
  output logic busy_o,
  output logic done_o
);
  gcd_state_e state_q, state_d;

  always_comb begin
    state_d  = state_q;
    sel_a_o  = 1'b0;
    sel_b_o  = 1'b0;
    ld_a_o   = 1'b0;
    ld_b_o   = 1'b0;
    ld_res_o = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        ld_a_o = start_i;
        ld_b_o = start_i;
        if (start_i) state_d = ST_STEP;
      end
      ST_STEP: begin
        if (a_ne_b_i) begin
          if (a_lt_b_i) begin
            sel_b_o = 1'b1;
            ld_b_o  = 1'b1;
          end else begin
            sel_a_o = 1'b1;
            ld_a_o  = 1'b1;
          end
        end else begin
          ld_res_o = 1'b1;
          state_d  = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      done_o  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_o  <= ld_res_o;
    end
  end

  assign busy_o = (state_q == ST_STEP);
endmodule

// File: rtl/gcd_sub_unit.sv
module gcd_sub_unit #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] opa_i,
  input  logic [W-1:0] opb_i,
  output logic [W-1:0] gcd_o,
  output logic         done_o
);
  logic sel_a, sel_b, ld_a, ld_b, ld_res;
  logic a_ne_b, a_lt_b, busy;
  logic [W-1:0] a_val, b_val;

  gcd_ctrl u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .a_ne_b_i (a_ne_b),
    .a_lt_b_i (a_lt_b),
    .sel_a_o  (sel_a),
    .sel_b_o  (sel_b),
    .ld_a_o   (ld_a),
    .ld_b_o   (ld_b),
    .ld_res_o (ld_res),
    .busy_o   (busy),
    .done_o   (done_o)
  );

  gcd_datapath #(.W(W)) u_dp (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .opa_i    (opa_i),
    .opb_i    (opb_i),
    .sel_a_i  (sel_a),
    .sel_b_i  (sel_b),
    .ld_a_i   (ld_a),
    .ld_b_i   (ld_b),
    .ld_res_i (ld_res),
    .a_ne_b_o (a_ne_b),
    .a_lt_b_o (a_lt_b),
    .a_o      (a_val),
    .b_o      (b_val),
    .res_o    (gcd_o)
  );
endmodule

// File: rtl/gcd_sub_unit_chk.sv
module gcd_sub_unit_chk #(
  parameter int W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         busy,
  input logic         sel_a,
  input logic         sel_b,
  input logic         ld_a,
  input logic         ld_b,
  input logic         ld_res,
  input logic [W-1:0] a_val,
  input logic [W-1:0] b_val,
  input logic [W-1:0] gcd_o,
  input logic         done_o
);
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R6
  AST_RESULT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(gcd_o)); // R6
  AST_ONE_ACTION: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ld_res, ld_a && sel_a, ld_b && sel_b})); // R3
  AST_BUSY_NO_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy && (ld_a || ld_b) |-> (sel_a || sel_b)); // R7
  AST_SUB_A_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_a && sel_a |-> (a_val > b_val) && (b_val != '0)); // R3
  AST_SUB_B_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_b && sel_b |-> (b_val > a_val) && (a_val != '0)); // R3
  AST_DONE_FROM_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(busy) && !busy); // R8
endmodule

bind gcd_sub_unit gcd_sub_unit_chk #(.W(W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .busy   (busy),
  .sel_a  (sel_a),
  .sel_b  (sel_b),
  .ld_a   (ld_a),
  .ld_b   (ld_b),
  .ld_res (ld_res),
  .a_val  (a_val),
  .b_val  (b_val),
  .gcd_o  (gcd_o),
  .done_o (done_o)
);

// File: tb/tb_gcd_sub_unit.sv
module tb_gcd_sub_unit;
  localparam int BW = 5;
  localparam int MAXV = (1 << BW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [BW-1:0] opa = '0, opb = '0;
  logic [BW-1:0] gcd;
  logic          done;
  int checks = 0, failures = 0;

  always #2 clk = ~clk;

  gcd_sub_unit #(.W(BW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .opa_i(opa), .opb_i(opb), .gcd_o(gcd), .done_o(done)
  );

  function automatic int ref_gcd(int a, int b);
    while (b != 0) begin
      int t = a % b;
      a = b;
      b = t;
    end
    return a;
  endfunction

  function automatic int ref_steps(int a, int b);
    int s = 0;
    while (a != b && a != 0 && b != 0) begin
      if (a < b) b = b - a; else a = a - b;
      s++;
    end
    return s;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // start one computation; poke=1 fires a foreign start while busy
  task automatic run(int a, int b, bit poke);
    int cnt = 0;
    int exp_lat = ref_steps(a, b) + 2;
    int exp_g = ref_gcd(a, b);
    opa = a[BW-1:0]; opb = b[BW-1:0]; start = 1'b1;
    while (!done && cnt < 200) begin
      @(negedge clk);
      cnt++;
      if (cnt == 1) begin
        start = poke;
        if (poke) begin opa = ~opa; opb = opb ^ 5'h3; end
      end else if (cnt == 2) start = 1'b0;
    end
    start = 1'b0;
    if (a == 0 || b == 0) check(gcd == exp_g, "R4", gcd, exp_g);
    else                  check(gcd == exp_g, "R3", gcd, exp_g);
    check(cnt == exp_lat, "R5", cnt, exp_lat);
    if (poke) begin
      logic [BW-1:0] held = gcd;
      for (int i = 0; i < 4; i++) begin
        @(negedge clk);
        check(!done && gcd == held, "R7", done, 0);
      end
    end else begin
      @(negedge clk);
      check(!done, "R6", done, 0);
    end
  endtask

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(gcd == 0 && done == 0, "R1", gcd, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(gcd == 0 && done == 0, "R1", gcd, 0);
    // R2: idle with start low does nothing
    opa = 5'd9; opb = 5'd6;
    repeat (5) begin
      @(negedge clk);
      check(!done && gcd == 0, "R2", done, 0);
    end
    // exhaustive sweep
    for (int a = 0; a <= MAXV; a++)
      for (int b = 0; b <= MAXV; b++)
        run(a, b, (a + b) % 7 == 3);
    // R8: start held through result, next accepted one edge later
    begin
      int cnt = 0;
      int lat = ref_steps(21, 6) + 2;
      opa = 5'd21; opb = 5'd6; start = 1'b1;
      while (!done && cnt < 200) begin @(negedge clk); cnt++; end
      check(gcd == 3 && cnt == lat, "R8", cnt, lat);
      cnt = 0;
      opa = 5'd20; opb = 5'd12;
      lat = ref_steps(20, 12) + 2;
      @(negedge clk); cnt++;
      while (!done && cnt < 200) begin @(negedge clk); cnt++; end
      start = 1'b0;
      check(gcd == 4, "R8", gcd, 4);
      check(cnt == lat, "R8", cnt, lat);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule